// File: doc/BRIEF.md
# Fast Page Mode DRAM Controller

This block connects a synchronous host request port to an asynchronous 1M x 4 DRAM that supports fast page mode. The host sees a flat 20-bit word address, 4-bit data, a valid/ready request handshake and a one-cycle read-data pulse. The DRAM side gets a shared 10-bit address bus that carries the row half and then the column half, the four active-low strobes, and a 4-bit data path. That data path is split into a drive value, a tri-state enable and a sampled input.

After an access the row stays open. A later access to the same row uses a CAS-only cycle, and an access to another row first closes the page and precharges. There are three operations: read, early write and read-modify-write. The read-modify-write samples the old word and then lowers WE while CAS is still low. The controller closes an open page before its RAS-low time runs out, and it serves refresh requests from an outside scheduler with a CAS-before-RAS cycle. Every timing interval is a parameter counted in clock cycles.

Top module: `fpm_dram_ctrl`

## Requirements
- R1: After reset, all four strobes are high, the DQ drive enable is low, `rd_valid` and `ref_ack` are low, and `req_ready` is high.
- R2: On every RAS falling edge the address bus carries `req_addr[19:10]`. On every CAS falling edge inside an access it carries `req_addr[9:0]`.
- R3: A read (`req_op` = 0) returns the addressed word on `rd_data` together with a one-cycle `rd_valid` pulse. On a page hit that pulse comes T_CAC+1 cycles after the handshake.
- R4: A write (`req_op` = 1) pulls WE low and drives DQ with the write data before CAS falls. The DRAM stores the data at the CAS falling edge.
- R5: A read-modify-write (`req_op` = 2) returns the old word through `rd_valid` and then stores the new word. WE falls while CAS is low, one or more cycles after DQ starts being driven and with OE high.
- R6: An access to the open row raises no new RAS falling edge.
- R7: An access to a different row raises RAS and holds it high for at least T_RP cycles before the new row falls.
- R8: The DQ drive enable is never high while OE is low.
- R9: RAS is never held low for T_RAS_MAX cycles or more. An idle open page is closed before that limit, and the next access to that row then opens it again.
- R10: When `ref_req` is high, any open page is closed and precharged. CAS then falls before RAS, `ref_ack` pulses for one cycle as RAS rises, and the page is reported closed afterwards.
- R11: At most one request is outstanding. `req_ready` is low from the cycle after a handshake until that access has finished, and it is low while `ref_req` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Controller can accept a request |
| req_op | input | 2 | 0 read, 1 write, 2 read-modify-write (3 acts as read) |
| req_addr | input | 20 | Word address, row in [19:10], column in [9:0] |
| req_wdata | input | 4 | Write data |
| rd_valid | output | 1 | One-cycle read data strobe |
| rd_data | output | 4 | Read data |
| ref_req | input | 1 | Refresh request from the scheduler, held until acknowledged |
| ref_ack | output | 1 | One-cycle pulse when the refresh cycle ends |
| dram_a | output | 10 | Multiplexed row/column address |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_oe_n | output | 1 | Output enable, active low |
| dram_dq_o | output | 4 | Data driven to the DRAM |
| dram_dq_oe | output | 1 | Tri-state enable for dram_dq_o |
| dram_dq_i | input | 4 | Data sampled from the DRAM |

## Verification
The hardest case to reach from the ports is the forced page close on the RAS-low limit, because it happens only when the host leaves an open row alone for a long time. The bench lowers T_RAS_MAX to 40, opens a row with one read, waits longer than the limit, and then confirms two things: RAS has gone high on its own, and the next access to the same row produces a fresh RAS falling edge. Refresh in the middle of an open page is handled in a similar way. The bench opens a row, raises `ref_req`, and checks that the following same-row access is treated as a miss. A behavioural DRAM model in the bench latches row and column on the strobe edges, which lets it catch address mux and write-ordering faults.

// File: rtl/fpm_pkg.sv
// Package fpm_pkg: shared operation codes and sequencer states for the
// fast page mode controller. Assumes a two-bit host operation field.
package fpm_pkg;
    typedef enum logic [1:0] {
        OP_READ  = 2'd0,
        OP_WRITE = 2'd1,
        OP_RMW   = 2'd2
    } fpm_op_e;

    typedef enum logic [3:0] {
        ST_IDLE, ST_PRE, ST_ROW, ST_RCD, ST_COL, ST_CASLOW,
        ST_RMWD, ST_RMWW, ST_WEHOLD, ST_CPRE, ST_REFC, ST_REFR
    } fpm_state_e;
endpackage

// File: rtl/fpm_addr_mux.sv
// fpm_addr_mux: places either the row half or the column half of a word
// address on the shared DRAM address bus. Assumes sel_col is registered so
// the bus is stable around every strobe edge.
module fpm_addr_mux #(
    parameter int ROW_W = 10,
    parameter int COL_W = 10
) (
    input  logic [ROW_W+COL_W-1:0] addr,
    input  logic                   sel_col,
    output logic [ROW_W-1:0]       a_out
);
    localparam int BUS_W = ROW_W;

    // Select row or zero-extended column onto the bus.
    always_comb begin
        a_out = addr[COL_W +: ROW_W];
        if (sel_col) begin
            a_out = '0;
            a_out[COL_W-1:0] = addr[COL_W-1:0];
        end
    end

    initial assert (BUS_W >= COL_W) else $error("column wider than bus");
endmodule

// File: rtl/fpm_ras_timer.sv
// fpm_ras_timer: counts consecutive cycles with RAS low and flags when the
// open page must be closed. Assumes the sequencer honours `expired` only at
// idle and that an access from idle takes fewer than MARGIN cycles.
module fpm_ras_timer #(
    parameter int T_RAS_MAX = 5000,
    parameter int MARGIN    = 12
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ras_n,
    output logic expired
);
    localparam int CW    = $clog2(T_RAS_MAX + 1);
    localparam int LIMIT = T_RAS_MAX - MARGIN;

    logic [CW-1:0] low_cnt;

    // Count RAS-low cycles, clear whenever RAS is high.
    always_ff @(posedge clk) begin
        if (!rst_n || ras_n) low_cnt <= '0;
        else if (low_cnt != CW'(T_RAS_MAX)) low_cnt <= low_cnt + 1'b1;
    end

    assign expired = (low_cnt >= CW'(LIMIT));

    // R9: the page is never held open up to the limit.
    assert_ras_max_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !ras_n |-> (low_cnt < CW'(T_RAS_MAX)));
endmodule

// File: rtl/fpm_dram_ctrl.sv
// fpm_dram_ctrl: fast page mode DRAM controller. Accepts one host request at
// a time, keeps the last row open for CAS-only hits, performs read, early
// write and read-modify-write, and inserts CAS-before-RAS refresh on request.
// Assumes the DRAM timing fits the cycle-count parameters and that ref_req
// stays high until ref_ack.
module fpm_dram_ctrl
    import fpm_pkg::*;
#(
    parameter int ROW_W     = 10,
    parameter int COL_W     = 10,
    parameter int DQ_W      = 4,
    parameter int T_RCD     = 3,
    parameter int T_CAS     = 1,
    parameter int T_CAC     = 2,
    parameter int T_RP      = 3,
    parameter int T_RFS     = 4,
    parameter int T_RAS_MAX = 5000
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   req_valid,
    output logic                   req_ready,
    input  logic [1:0]             req_op,
    input  logic [ROW_W+COL_W-1:0] req_addr,
    input  logic [DQ_W-1:0]        req_wdata,
    output logic                   rd_valid,
    output logic [DQ_W-1:0]        rd_data,
    input  logic                   ref_req,
    output logic                   ref_ack,
    output logic [ROW_W-1:0]       dram_a,
    output logic                   dram_ras_n,
    output logic                   dram_cas_n,
    output logic                   dram_we_n,
    output logic                   dram_oe_n,
    output logic [DQ_W-1:0]        dram_dq_o,
    output logic                   dram_dq_oe,
    input  logic [DQ_W-1:0]        dram_dq_i
);
    localparam int ADDR_W  = ROW_W + COL_W;
    localparam int T_A     = (T_RCD > T_CAS) ? T_RCD : T_CAS;
    localparam int T_B     = (T_CAC > T_RP)  ? T_CAC : T_RP;
    localparam int T_C     = (T_A > T_B)     ? T_A   : T_B;
    localparam int T_MAX   = (T_C > T_RFS)   ? T_C   : T_RFS;
    localparam int CNT_W   = $clog2(T_MAX + 1);
    localparam int ACC_MAX = T_CAC + T_CAS + 8;

    fpm_state_e          state, nxt;
    fpm_op_e             op_q;
    logic [ADDR_W-1:0]   addr_q;
    logic [DQ_W-1:0]     wdata_q;
    logic [ROW_W-1:0]    open_row;
    logic                row_open, sel_col, ras_expired;
    logic [CNT_W-1:0]    cnt;
    logic                req_hit;

    fpm_addr_mux #(.ROW_W(ROW_W), .COL_W(COL_W)) u_amux (
        .addr(addr_q), .sel_col(sel_col), .a_out(dram_a));

    fpm_ras_timer #(.T_RAS_MAX(T_RAS_MAX), .MARGIN(ACC_MAX)) u_rtimer (
        .clk(clk), .rst_n(rst_n), .ras_n(dram_ras_n), .expired(ras_expired));

    // Ready only at idle when neither refresh nor a forced close is due.
    assign req_ready = (state == ST_IDLE) && !ref_req && !(row_open && ras_expired);
    // Incoming request targets the row already open.
    assign req_hit   = row_open && (req_addr[COL_W +: ROW_W] == open_row);

    // Main sequencer: strobes, data path, page bookkeeping and host replies.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;  nxt <= ST_IDLE;  op_q <= OP_READ;
            dram_ras_n <= 1'b1; dram_cas_n <= 1'b1; dram_we_n <= 1'b1; dram_oe_n <= 1'b1;
            dram_dq_oe <= 1'b0; dram_dq_o <= '0; sel_col <= 1'b0;
            row_open <= 1'b0; open_row <= '0; cnt <= '0;
            addr_q <= '0; wdata_q <= '0; rd_valid <= 1'b0; rd_data <= '0; ref_ack <= 1'b0;
        end else begin
            rd_valid <= 1'b0;
            ref_ack  <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (ref_req || (row_open && ras_expired)) begin
                        if (row_open) begin
                            dram_ras_n <= 1'b1; row_open <= 1'b0; sel_col <= 1'b0;
                            cnt <= CNT_W'(T_RP - 1); nxt <= ST_IDLE; state <= ST_PRE;
                        end else begin
                            dram_cas_n <= 1'b0; state <= ST_REFC;
                        end
                    end else if (req_valid) begin
                        op_q <= (req_op == OP_WRITE) ? OP_WRITE :
                                (req_op == OP_RMW)   ? OP_RMW : OP_READ;
                        addr_q <= req_addr; wdata_q <= req_wdata;
                        if (req_hit) begin
                            sel_col <= 1'b1;
                            if (req_op == OP_WRITE) begin
                                dram_we_n <= 1'b0; dram_dq_oe <= 1'b1; dram_dq_o <= req_wdata;
                            end
                            state <= ST_COL;
                        end else if (row_open) begin
                            dram_ras_n <= 1'b1; row_open <= 1'b0; sel_col <= 1'b0;
                            cnt <= CNT_W'(T_RP - 1); nxt <= ST_ROW; state <= ST_PRE;
                        end else begin
                            state <= ST_ROW;
                        end
                    end
                end
                ST_PRE: begin
                    if (cnt == '0) state <= nxt;
                    else cnt <= cnt - 1'b1;
                end
                ST_ROW: begin
                    dram_ras_n <= 1'b0; row_open <= 1'b1;
                    open_row <= addr_q[COL_W +: ROW_W];
                    cnt <= CNT_W'(T_RCD - 1); state <= ST_RCD;
                end
                ST_RCD: begin
                    if (cnt != '0) cnt <= cnt - 1'b1;
                    else begin
                        sel_col <= 1'b1;
                        if (op_q == OP_WRITE) begin
                            dram_we_n <= 1'b0; dram_dq_oe <= 1'b1; dram_dq_o <= wdata_q;
                        end
                        state <= ST_COL;
                    end
                end
                ST_COL: begin
                    dram_cas_n <= 1'b0;
                    dram_oe_n  <= (op_q == OP_WRITE);
                    cnt   <= (op_q == OP_WRITE) ? CNT_W'(T_CAS - 1) : CNT_W'(T_CAC - 1);
                    state <= ST_CASLOW;
                end
                ST_CASLOW: begin
                    if (cnt != '0) cnt <= cnt - 1'b1;
                    else if (op_q == OP_WRITE) begin
                        dram_cas_n <= 1'b1; dram_we_n <= 1'b1; dram_dq_oe <= 1'b0;
                        state <= ST_CPRE;
                    end else begin
                        rd_data <= dram_dq_i; rd_valid <= 1'b1; dram_oe_n <= 1'b1;
                        if (op_q == OP_RMW) state <= ST_RMWD;
                        else begin dram_cas_n <= 1'b1; state <= ST_CPRE; end
                    end
                end
                ST_RMWD: begin
                    dram_dq_oe <= 1'b1; dram_dq_o <= wdata_q; state <= ST_RMWW;
                end
                ST_RMWW: begin
                    dram_we_n <= 1'b0; cnt <= CNT_W'(T_CAS - 1); state <= ST_WEHOLD;
                end
                ST_WEHOLD: begin
                    if (cnt != '0) cnt <= cnt - 1'b1;
                    else begin
                        dram_cas_n <= 1'b1; dram_we_n <= 1'b1; dram_dq_oe <= 1'b0;
                        state <= ST_CPRE;
                    end
                end
                ST_CPRE: begin
                    sel_col <= 1'b0; state <= ST_IDLE;
                end
                ST_REFC: begin
                    dram_ras_n <= 1'b0; cnt <= CNT_W'(T_RFS - 1); state <= ST_REFR;
                end
                ST_REFR: begin
                    if (cnt != '0) cnt <= cnt - 1'b1;
                    else begin
                        dram_ras_n <= 1'b1; dram_cas_n <= 1'b1; ref_ack <= 1'b1;
                        cnt <= CNT_W'(T_RP - 1); nxt <= ST_IDLE; state <= ST_PRE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R8: own drivers off whenever the DRAM may drive.
    assert_dq_oe_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(dram_dq_oe && !dram_oe_n));
    // R4: an early write has data on the bus when CAS falls.
    assert_early_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(dram_cas_n) && !dram_we_n) |-> dram_dq_oe);
    // R5: a late WE edge follows data already driven, with OE released.
    assert_late_we_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(dram_we_n) && !dram_cas_n) |-> ($past(dram_dq_oe) && dram_oe_n));
    // R3: read data strobe lasts a single cycle.
    assert_rd_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid);
    // R10: RAS falling with CAS low only after CAS was already low.
    assert_cbr_order_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(dram_ras_n) && !dram_cas_n) |-> $past(!dram_cas_n));
    // R10: refresh ends with RAS high and the page closed.
    assert_ref_close_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ref_ack |-> (dram_ras_n && !row_open));
    // R11: no second request accepted right after a handshake.
    assert_one_req_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);
endmodule

// File: tb/fpm_dram_ctrl_tb.sv
module fpm_dram_ctrl_tb;
    localparam int CLK_PERIOD = 20;
    localparam int T_CAC      = 2;
    localparam int T_RP       = 3;
    localparam int T_RAS_MAX  = 40;

    logic        clk = 1'b0, rst_n = 1'b0;
    logic        req_valid = 1'b0, req_ready;
    logic [1:0]  req_op = 2'd0;
    logic [19:0] req_addr = '0;
    logic [3:0]  req_wdata = '0;
    logic        rd_valid;
    logic [3:0]  rd_data;
    logic        ref_req = 1'b0, ref_ack;
    logic [9:0]  dram_a;
    logic        dram_ras_n, dram_cas_n, dram_we_n, dram_oe_n, dram_dq_oe;
    logic [3:0]  dram_dq_o, dram_dq_i;

    int n_checks = 0, n_fail = 0;
    int ras_falls = 0, cbr_count = 0, conflicts = 0;
    int hi_run = 0, min_pre = 1000;
    bit seen_low = 0;
    int last_lat = 0;
    logic [3:0] last_rd = '0;

    logic [3:0] mem [int];
    logic [9:0] m_row = '0, m_col = '0;
    logic [3:0] m_q = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fpm_dram_ctrl #(.T_CAC(T_CAC), .T_RP(T_RP), .T_RAS_MAX(T_RAS_MAX)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_op(req_op), .req_addr(req_addr), .req_wdata(req_wdata),
        .rd_valid(rd_valid), .rd_data(rd_data), .ref_req(ref_req), .ref_ack(ref_ack),
        .dram_a(dram_a), .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n),
        .dram_we_n(dram_we_n), .dram_oe_n(dram_oe_n), .dram_dq_o(dram_dq_o),
        .dram_dq_oe(dram_dq_oe), .dram_dq_i(dram_dq_i));

    // Behavioural DRAM: strobe-edge latching, late-edge write capture.
    always @(negedge dram_ras_n) begin
        if (!dram_cas_n) cbr_count++;
        else begin m_row = dram_a; ras_falls++; end
    end
    always @(negedge dram_cas_n) begin
        if (!dram_ras_n) begin
            m_col = dram_a;
            if (!dram_we_n) mem[int'({m_row, m_col})] = dram_dq_o;
            else m_q = mem.exists(int'({m_row, m_col})) ? mem[int'({m_row, m_col})] : 4'h0;
        end
    end
    always @(negedge dram_we_n) begin
        if (!dram_cas_n && !dram_ras_n) mem[int'({m_row, m_col})] = dram_dq_o;
    end
    assign dram_dq_i = (!dram_cas_n && !dram_oe_n) ? m_q : 4'h0;

    // Bus conflict and precharge-length monitor.
    always @(negedge clk) begin
        if (rst_n) begin
            if (dram_dq_oe && !dram_oe_n) conflicts++;
            if (dram_ras_n) hi_run++;
            else begin
                if (seen_low && hi_run > 0 && hi_run < min_pre) min_pre = hi_run;
                seen_low = 1; hi_run = 0;
            end
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wait_ready();
        int guard = 0;
        while (!req_ready && guard < 500) begin @(negedge clk); guard++; end
    endtask

    // Issue one request; captures read data and latency when op returns data.
    task automatic do_access(input logic [1:0] op, input logic [19:0] addr,
                             input logic [3:0] wd);
        int guard = 0;
        @(negedge clk);
        wait_ready();
        req_valid = 1'b1; req_op = op; req_addr = addr; req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
        check(req_ready == 1'b0, "R11", int'(req_ready), 0);
        if (op != 2'd1) begin
            last_lat = 0;
            while (!rd_valid && guard < 200) begin @(negedge clk); last_lat++; guard++; end
            last_rd = rd_data;
        end
        wait_ready();
    endtask

    task automatic t_reset();
        check(dram_ras_n && dram_cas_n && dram_we_n && dram_oe_n, "R1",
              {dram_ras_n, dram_cas_n, dram_we_n, dram_oe_n}, 15);
        check(!dram_dq_oe && !rd_valid && !ref_ack, "R1",
              {dram_dq_oe, rd_valid, ref_ack}, 0);
        check(req_ready == 1'b1, "R1", int'(req_ready), 1);
    endtask

    task automatic t_write_read_hit();
        int rf;
        do_access(2'd1, {10'd5, 10'd3}, 4'hA);
        check(mem.exists(int'({10'd5, 10'd3})) && mem[int'({10'd5, 10'd3})] == 4'hA,
              "R4", mem.exists(int'({10'd5, 10'd3})) ? int'(mem[int'({10'd5, 10'd3})]) : -1, 10);
        check(m_row == 10'd5 && m_col == 10'd3, "R2", int'({m_row, m_col}), int'({10'd5, 10'd3}));
        rf = ras_falls;
        do_access(2'd0, {10'd5, 10'd3}, 4'h0);
        check(last_rd == 4'hA, "R3", int'(last_rd), 10);
        check(last_lat == T_CAC + 1, "R3", last_lat, T_CAC + 1);
        check(ras_falls == rf, "R6", ras_falls - rf, 0);
    endtask

    task automatic t_row_miss();
        int rf = ras_falls;
        do_access(2'd1, {10'd700, 10'd1000}, 4'h6);
        check(ras_falls == rf + 1, "R7", ras_falls - rf, 1);
        check(m_row == 10'd700 && m_col == 10'd1000, "R2", int'(m_row), 700);
        do_access(2'd0, {10'd5, 10'd3}, 4'h0);
        check(last_rd == 4'hA, "R3", int'(last_rd), 10);
        do_access(2'd0, {10'd700, 10'd1000}, 4'h0);
        check(last_rd == 4'h6, "R3", int'(last_rd), 6);
        check(min_pre >= T_RP, "R7", min_pre, T_RP);
    endtask

    task automatic t_rmw();
        do_access(2'd2, {10'd700, 10'd1000}, 4'h9);
        check(last_rd == 4'h6, "R5", int'(last_rd), 6);
        check(mem[int'({10'd700, 10'd1000})] == 4'h9, "R5",
              int'(mem[int'({10'd700, 10'd1000})]), 9);
        do_access(2'd0, {10'd700, 10'd1000}, 4'h0);
        check(last_rd == 4'h9, "R5", int'(last_rd), 9);
    endtask

    task automatic t_ras_limit();
        int rf;
        do_access(2'd0, {10'd22, 10'd4}, 4'h0);
        repeat (T_RAS_MAX + 20) @(negedge clk);
        check(dram_ras_n == 1'b1, "R9", int'(dram_ras_n), 1);
        rf = ras_falls;
        do_access(2'd0, {10'd22, 10'd4}, 4'h0);
        check(ras_falls == rf + 1, "R9", ras_falls - rf, 1);
    endtask

    task automatic t_refresh();
        int rf, cb, guard = 0;
        do_access(2'd1, {10'd9, 10'd9}, 4'h3);
        cb = cbr_count;
        @(negedge clk);
        ref_req = 1'b1;
        @(negedge clk);
        check(req_ready == 1'b0, "R11", int'(req_ready), 0);
        while (!ref_ack && guard < 200) begin @(negedge clk); guard++; end
        check(ref_ack == 1'b1 && dram_ras_n == 1'b1, "R10", {ref_ack, dram_ras_n}, 3);
        ref_req = 1'b0;
        @(negedge clk);
        check(ref_ack == 1'b0, "R10", int'(ref_ack), 0);
        check(cbr_count == cb + 1, "R10", cbr_count - cb, 1);
        rf = ras_falls;
        do_access(2'd0, {10'd9, 10'd9}, 4'h0);
        check(ras_falls == rf + 1 && last_rd == 4'h3, "R10", ras_falls - rf, 1);
    endtask

    initial begin
        int cyc = 0;
        while (cyc < 20000) begin @(posedge clk); cyc++; end
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual %0d expected 0", cyc);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_write_read_hit();
        t_row_miss();
        t_rmw();
        t_ras_limit();
        t_refresh();
        check(conflicts == 0, "R8", conflicts, 0);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule